// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits beside a processor that does not drive its own bus strobes. Ahead of every bus cycle the processor puts out a 3-bit cycle-type code. The block watches that code and rebuilds the timed command strobes from it: memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also drives the address-latch pulse, the data-transceiver enable and the transfer-direction control.

A cycle begins when the code leaves the idle value 111. The address-latch pulse marks the first clock of the cycle. From the second clock the matching command strobe stays low until the code goes back to 111. For an interrupt-acknowledge cycle the direction line switches to receive, and the same happens for the read cycles. The data enable is high only while a command strobe is active. A halt code produces an address-latch pulse and nothing else.

Top module: `bus_cmd_decoder`

## Requirements
- R1: While reset is asserted and after it is released, every command strobe is high, addr_strobe and data_en are 0 and dir_xmit is 1.
- R2: In the clock after bus_stat is sampled as 111, every strobe is high, addr_strobe and data_en are 0 and dir_xmit is 1.
- R3: The first non-111 sample after a 111 sample (or after reset) starts a cycle. addr_strobe is 1 for exactly the next clock and no strobe is low in that clock.
- R4: From the second clock of a cycle until 111 is sampled, one strobe is low. The code decides which: 000 int_ack_n, 001 io_rd_n, 010 io_wr_n, 100 and 101 mem_rd_n, 110 mem_wr_n.
- R5: Code 011 (halt) gives the address-latch pulse but no strobe and no data_en.
- R6: dir_xmit is 0 from the address-latch clock to the end of a cycle started by 000, 001, 100 or 101. It stays 1 for 010, 110 and 011.
- R7: data_en is 1 exactly in the clocks in which a command strobe is low.
- R8: If the code changes from one non-111 value to another without passing through 111, the change is ignored. The running cycle keeps its strobe and direction.
- R9: At most one command strobe is low in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_stat | input | 3 | Cycle-type code from the processor, 111 = idle |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| int_ack_n | output | 1 | Interrupt acknowledge strobe, active low |
| addr_strobe | output | 1 | Address latch pulse, active high |
| data_en | output | 1 | Data transceiver enable, active high |
| dir_xmit | output | 1 | 1 = transmit (write), 0 = receive (read) |

## Verification
Some rules can be judged from the signals in a single clock or two, and the assertions check these on every cycle. At most one strobe is low. The address pulse lasts one clock. The data enable follows the strobes. A read strobe always comes with the receive direction. An idle sample clears everything in the next clock.

Other properties depend on the whole history of a cycle and only the bench's scenarios can show them. These are the mapping from each code to its strobe, the one-clock delay before the strobe, how long the strobe lasts for different status hold times, and the rule that a code change in mid-cycle is ignored. The bench covers every code with several hold lengths.

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_stat,
  output logic       mem_rd_n,
  output logic       mem_wr_n,
  output logic       io_rd_n,
  output logic       io_wr_n,
  output logic       int_ack_n,
  output logic       addr_strobe,
  output logic       data_en,
  output logic       dir_xmit
);
  localparam logic [2:0] IDLE = 3'b111;
  localparam logic [2:0] HALT = 3'b011;

  logic       busy, cmd_on;
  logic [2:0] cyc;

  function automatic logic is_rx(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b001) || (c == 3'b100) || (c == 3'b101);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cmd_on      <= 1'b0;
      addr_strobe <= 1'b0;
      dir_xmit    <= 1'b1;
      cyc         <= IDLE;
    end else if (bus_stat == IDLE) begin
      busy        <= 1'b0;
      cmd_on      <= 1'b0;
      addr_strobe <= 1'b0;
      dir_xmit    <= 1'b1;
    end else if (!busy) begin
      busy        <= 1'b1;
      addr_strobe <= 1'b1;
      cyc         <= bus_stat;
      dir_xmit    <= !is_rx(bus_stat);
    end else begin
      addr_strobe <= 1'b0;
      cmd_on      <= (cyc != HALT);
    end
  end

  assign int_ack_n = !(cmd_on && cyc == 3'b000);
  assign io_rd_n   = !(cmd_on && cyc == 3'b001);
  assign io_wr_n   = !(cmd_on && cyc == 3'b010);
  assign mem_rd_n  = !(cmd_on && (cyc == 3'b100 || cyc == 3'b101));
  assign mem_wr_n  = !(cmd_on && cyc == 3'b110);
  assign data_en   = !(int_ack_n && io_rd_n && io_wr_n && mem_rd_n && mem_wr_n);

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~int_ack_n, ~io_rd_n, ~io_wr_n, ~mem_rd_n, ~mem_wr_n}) <= 1);
  // R3
  ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> !addr_strobe);
  // R2
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stat == IDLE) |=> (!data_en && !addr_strobe && dir_xmit && mem_rd_n && io_rd_n));
  // R6
  rx_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !io_rd_n || !int_ack_n) |-> !dir_xmit);
  // R3
  ale_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |-> !data_en);
endmodule

// File: tb/test_bus_cmd_decoder.sv
module test_bus_cmd_decoder;
  logic clk = 0, rst_n = 0;
  logic [2:0] bus_stat = 3'b111;
  logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n, addr_strobe, data_en, dir_xmit;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  bus_cmd_decoder i_bus_cmd_decoder (.*);

  // {int_ack_n, io_rd_n, io_wr_n, mem_rd_n, mem_wr_n, addr_strobe, data_en, dir_xmit}
  function automatic logic [7:0] expect_vec(input logic [2:0] c, input int ph);
    logic [4:0] s = 5'b11111;
    logic rx = (c == 0) || (c == 1) || (c == 4) || (c == 5);
    if (ph == 0) return 8'b11111_001;
    if (ph == 1) return {5'b11111, 1'b1, 1'b0, !rx};
    case (c)
      3'd0: s[4] = 0;
      3'd1: s[3] = 0;
      3'd2: s[2] = 0;
      3'd4, 3'd5: s[1] = 0;
      3'd6: s[0] = 0;
      default: ;
    endcase
    return {s, 1'b0, (c != 3), !rx};
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    logic [7:0] act = {int_ack_n, io_rd_n, io_wr_n, mem_rd_n, mem_wr_n, addr_strobe, data_en, dir_xmit};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] c, input int len);
    @(negedge clk) bus_stat = c;
    for (int n = 1; n <= len; n++) begin
      @(negedge clk);
      if (n == 1) check(c == 3 ? "R5 R3" : "R3 R6", expect_vec(c, 1));
      else        check(c == 3 ? "R5" : "R4 R6 R7", expect_vec(c, 2));
      if (n == len) bus_stat = 3'b111;
    end
    @(negedge clk) check("R2", expect_vec(c, 0));
  endtask

  initial begin
    #1000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", expect_vec(0, 0));
    rst_n = 1;
    @(negedge clk) check("R1", expect_vec(0, 0));
    for (int c = 0; c < 7; c++)
      for (int len = 1; len <= 4; len++)
        run(3'(c), len);
    // R8: mid-cycle code change ignored
    for (int a = 0; a < 7; a++) begin
      int b = (a + 2) % 7;
      @(negedge clk) bus_stat = 3'(a);
      @(negedge clk) check("R8", expect_vec(3'(a), 1));
      bus_stat = 3'(b);
      @(negedge clk) check("R8", expect_vec(3'(a), 2));
      @(negedge clk) check("R8", expect_vec(3'(a), 2));
      bus_stat = 3'b111;
      @(negedge clk) check("R2", expect_vec(3'(a), 0));
    end
    // R9 spot check via idle stays idle
    @(negedge clk) check("R9 R2", expect_vec(0, 0));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule